// File: doc/BRIEF.md
# Serial Bus Control and Status Register

This block is the eight-bit control and status register of one node on a multi-drop serial message bus. A host processor reads it and writes it. The node's serial engine drives strobes into it at fixed points of each message. These strobes set sticky status bits when an acknowledge is missed, when an incoming message is addressed to this node, and when a message starts before the previous one has been read. The block also carries two start-up configuration bits. One names this node as the previous bus master. The other names it as the source of the serial clock.

The block combines the master, missed-acknowledge and read-pending bits with an enable from the bus control register to form an interrupt request. A sticky interrupt flag records that request. Software clears the flag by writing a one to it. The register is read back directly on `rd_data`. Every status bit changes on the clock edge after the event that causes it.

Top module: `sbs_ctrl_status`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `rd_data` is 0x00 and `irq` is 0.
- R2: A write (`wr_en`=1) loads `wr_data[6]` into bit 6 (clock source) and `wr_data[2]` into bit 2 (previous master). Both bits hold their value when there is no write.
- R3: Bit 4 (read pending) is 1 on the cycle after `addr_match` is pulsed.
- R4: Bit 4 goes to 0 on the cycle after `last_rd` is pulsed. If `addr_match` and `last_rd` are high in the same cycle, bit 4 becomes 1.
- R5: When `msg_start` is pulsed while bit 4 is 1, bit 5 (deaf) is 1 on the next cycle.
- R6: When `msg_start` is pulsed while bit 4 is 0, bit 5 is 0 on the next cycle. Bit 5 holds its value between message starts.
- R7: Bit 3 (not acknowledged) is set on the next cycle when bit 1 is 1, `bus_state` equals 36 and `sdata` is 1. It clears on the cycle after a `msg_start`. If the set condition and a message start occur together, the set wins. No other state or data value sets bit 3.
- R8: Bits 1 (master) and 0 (write pending) show `master_in` and `wr_pend_in` one cycle later. Writes have no effect on them.
- R9: `irq` equals `bus_irq_en` AND (bit 1 OR bit 3 OR bit 4), evaluated combinationally from the current register value.
- R10: Bit 7 (interrupt flag) is 1 on the cycle after any cycle in which `irq` is 1. A write with `wr_data[7]`=1 clears it only when `irq` is 0 in that same cycle. Writing 0 to bit 7 leaves it unchanged.
- R11: Writes do not change bits 5, 4 and 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Processor write strobe for the register |
| wr_data | input | 8 | Processor write data |
| rd_data | output | 8 | Current register value |
| bus_irq_en | input | 1 | Interrupt enable from the bus control register |
| bus_state | input | STATE_W | Serial bus timing-state counter |
| sdata | input | 1 | Serial data line |
| master_in | input | 1 | This node currently owns the bus |
| wr_pend_in | input | 1 | A write to the bus is pending |
| addr_match | input | 1 | Strobe: the incoming address field matched this node |
| msg_start | input | 1 | Strobe: a message has started on the bus |
| last_rd | input | 1 | Strobe: the processor read the final message byte |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that each strobe is high for one clock for each event. They also assume that `bus_state` and `sdata` are stable from one clock edge to the next. The write-ignore property assumes that no hardware event coincides with the write it is checking. The bench changes every input just after the falling clock edge, so each value is settled by the rising edge. Its strobes are single-cycle pulses, drawn with low probability. `bus_state` is drawn from a narrow band around 36, so the missed-acknowledge state occurs often.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    // Register layout: bit order is the software-visible map.
    typedef struct packed {
        logic flag;      // 7: sticky interrupt flag
        logic clk_src;   // 6: serial clock source select
        logic deaf;      // 5: message missed, previous unread
        logic rd_pend;   // 4: received message awaits reading
        logic nack;      // 3: last sent message not acknowledged
        logic prev_mst;  // 2: previous master marker
        logic master;    // 1: node owns the bus
        logic wr_pend;   // 0: bus write pending
    } sbs_reg_t;

    localparam int REG_W = $bits(sbs_reg_t);
endpackage

// File: rtl/sbs_nack_detect.sv
module sbs_nack_detect #(
    parameter int STATE_W    = 6,
    parameter int NACK_STATE = 36
) (
    input  logic               master,
    input  logic [STATE_W-1:0] bus_state,
    input  logic               sdata,
    output logic               nack_hit
);
    localparam logic [STATE_W-1:0] NACK_CODE = STATE_W'(NACK_STATE);

    // Acknowledge slot sampled high while this node sends.
    always_comb begin
        nack_hit = master && (bus_state == NACK_CODE) && sdata;
    end
endmodule

// File: rtl/sbs_status_next.sv
module sbs_status_next (
    input  logic rd_pend_q,
    input  logic deaf_q,
    input  logic nack_q,
    input  logic addr_match,
    input  logic msg_start,
    input  logic last_rd,
    input  logic nack_hit,
    output logic rd_pend_d,
    output logic deaf_d,
    output logic nack_d
);
    always_comb begin
        // Set wins over clear for every sticky bit.
        if (addr_match) begin
            rd_pend_d = 1'b1;
        end else if (last_rd) begin
            rd_pend_d = 1'b0;
        end else begin
            rd_pend_d = rd_pend_q;
        end

        // Each message start re-evaluates the deaf state.
        deaf_d = msg_start ? rd_pend_q : deaf_q;

        if (nack_hit) begin
            nack_d = 1'b1;
        end else if (msg_start) begin
            nack_d = 1'b0;
        end else begin
            nack_d = nack_q;
        end
    end
endmodule

// File: rtl/sbs_irq_unit.sv
module sbs_irq_unit (
    input  logic bus_irq_en,
    input  logic master_q,
    input  logic nack_q,
    input  logic rd_pend_q,
    input  logic flag_q,
    input  logic flag_w1c,
    output logic irq,
    output logic flag_d
);
    always_comb begin
        irq    = bus_irq_en && (master_q || nack_q || rd_pend_q);
        flag_d = irq || (flag_q && !flag_w1c);
    end
endmodule

// File: rtl/sbs_ctrl_status.sv
module sbs_ctrl_status
    import sbs_pkg::*;
#(
    parameter int STATE_W    = 6,
    parameter int NACK_STATE = 36
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    output logic [7:0]         rd_data,
    input  logic               bus_irq_en,
    input  logic [STATE_W-1:0] bus_state,
    input  logic               sdata,
    input  logic               master_in,
    input  logic               wr_pend_in,
    input  logic               addr_match,
    input  logic               msg_start,
    input  logic               last_rd,
    output logic               irq
);
    sbs_reg_t reg_d, reg_q;
    sbs_reg_t wr_view;
    logic     nack_hit;
    logic     rd_pend_d, deaf_d, nack_d, flag_d;
    logic     flag_w1c;

    always_comb wr_view = sbs_reg_t'(wr_data[REG_W-1:0]);

    sbs_nack_detect #(
        .STATE_W   (STATE_W),
        .NACK_STATE(NACK_STATE)
    ) u_nack (
        .master   (reg_q.master),
        .bus_state(bus_state),
        .sdata    (sdata),
        .nack_hit (nack_hit)
    );

    sbs_status_next u_next (
        .rd_pend_q (reg_q.rd_pend),
        .deaf_q    (reg_q.deaf),
        .nack_q    (reg_q.nack),
        .addr_match(addr_match),
        .msg_start (msg_start),
        .last_rd   (last_rd),
        .nack_hit  (nack_hit),
        .rd_pend_d (rd_pend_d),
        .deaf_d    (deaf_d),
        .nack_d    (nack_d)
    );

    always_comb flag_w1c = wr_en && wr_view.flag;

    sbs_irq_unit u_irq (
        .bus_irq_en(bus_irq_en),
        .master_q  (reg_q.master),
        .nack_q    (reg_q.nack),
        .rd_pend_q (reg_q.rd_pend),
        .flag_q    (reg_q.flag),
        .flag_w1c  (flag_w1c),
        .irq       (irq),
        .flag_d    (flag_d)
    );

    always_comb begin
        reg_d          = reg_q;
        reg_d.flag     = flag_d;
        reg_d.deaf     = deaf_d;
        reg_d.rd_pend  = rd_pend_d;
        reg_d.nack     = nack_d;
        reg_d.master   = master_in;
        reg_d.wr_pend  = wr_pend_in;
        if (wr_en) begin
            reg_d.clk_src  = wr_view.clk_src;
            reg_d.prev_mst = wr_view.prev_mst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_q <= '0;
        end else begin
            reg_q <= reg_d;
        end
    end

    always_comb rd_data = reg_q;

    // R3 read pending follows an address match
    a_r3_match_sets: assert property (@(posedge clk) disable iff (!rst_n)
        addr_match |=> rd_data[4]);
    // R4 final byte read clears read pending
    a_r4_last_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (last_rd && !addr_match) |=> !rd_data[4]);
    // R5 start while unread makes the node deaf
    a_r5_deaf_set: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_start && rd_data[4]) |=> rd_data[5]);
    // R6 start with nothing unread clears deaf
    a_r6_deaf_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_start && !rd_data[4]) |=> !rd_data[5]);
    // R7 missed acknowledge in the check state
    a_r7_nack_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[1] && bus_state == STATE_W'(NACK_STATE) && sdata) |=> rd_data[3]);
    // R8 write cannot alter the live master bit
    a_r8_master_follows: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data[1] == $past(master_in)));
    // R10 flag survives when not cleared
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7] && !(wr_en && wr_data[7])) |=> rd_data[7]);
    // R10 raised request always lands in the flag
    a_r10_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> rd_data[7]);
    // R11 status bits ignore writes when no event occurs
    a_r11_status_ro: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !addr_match && !msg_start && !last_rd && !nack_hit)
        |=> $stable(rd_data[5:3]));
endmodule

// File: tb/tb_sbs_ctrl_status.sv
module tb_sbs_ctrl_status;
    localparam int STATE_W = 6;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               wr_en = 1'b0;
    logic [7:0]         wr_data = '0;
    logic [7:0]         rd_data;
    logic               bus_irq_en = 1'b0;
    logic [STATE_W-1:0] bus_state = '0;
    logic               sdata = 1'b0;
    logic               master_in = 1'b0;
    logic               wr_pend_in = 1'b0;
    logic               addr_match = 1'b0;
    logic               msg_start = 1'b0;
    logic               last_rd = 1'b0;
    logic               irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural reference state
    bit m_flag, m_clk, m_deaf, m_rp, m_nack, m_prev, m_mst, m_wp;

    always #4 clk = ~clk;

    sbs_ctrl_status #(.STATE_W(STATE_W), .NACK_STATE(36)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .bus_irq_en(bus_irq_en), .bus_state(bus_state),
        .sdata(sdata), .master_in(master_in), .wr_pend_in(wr_pend_in),
        .addr_match(addr_match), .msg_start(msg_start), .last_rd(last_rd),
        .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit model_irq();
        return bus_irq_en && (m_mst || m_nack || m_rp);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {m_flag, m_clk, m_deaf, m_rp, m_nack, m_prev, m_mst, m_wp} = '0;
        end else begin
            bit irq_now, rp_old, hit;
            irq_now = model_irq();
            rp_old  = m_rp;
            hit     = m_mst && (bus_state == 36) && sdata;
            m_flag  = irq_now || (m_flag && !(wr_en && wr_data[7]));
            if (addr_match) m_rp = 1'b1;
            else if (last_rd) m_rp = 1'b0;
            if (msg_start) m_deaf = rp_old;
            if (hit) m_nack = 1'b1;
            else if (msg_start) m_nack = 1'b0;
            if (wr_en) begin
                m_clk  = wr_data[6];
                m_prev = wr_data[2];
            end
            m_mst = master_in;
            m_wp  = wr_pend_in;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(rd_data[7] == m_flag, "R10 flag", rd_data[7], m_flag);
            chk(rd_data[6] == m_clk,  "R2 clk_src", rd_data[6], m_clk);
            chk(rd_data[5] == m_deaf, "R5 deaf", rd_data[5], m_deaf);
            chk(rd_data[4] == m_rp,   "R3 rd_pend", rd_data[4], m_rp);
            chk(rd_data[3] == m_nack, "R7 nack", rd_data[3], m_nack);
            chk(rd_data[2] == m_prev, "R2 prev_mst", rd_data[2], m_prev);
            chk(rd_data[1:0] == {m_mst, m_wp}, "R8 master/wpend", rd_data[1:0], {m_mst, m_wp});
            chk(irq == model_irq(), "R9 irq", irq, model_irq());
        end
    end

    task automatic tick();
        @(negedge clk);
        wr_en = 1'b0; addr_match = 1'b0; msg_start = 1'b0; last_rd = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(rd_data == 8'h00 && irq == 1'b0, "R1 in reset", rd_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(rd_data == 8'h00 && irq == 1'b0, "R1 after reset", rd_data, 0);

        wr_en = 1'b1; wr_data = 8'hFF; tick();
        chk(rd_data == 8'h44, "R11 write all ones", rd_data, 8'h44);
        chk(rd_data[6] && rd_data[2], "R2 config bits set", rd_data, 8'h44);

        bus_irq_en = 1'b1; addr_match = 1'b1; tick();
        chk(rd_data[4] == 1'b1, "R3 match sets", rd_data[4], 1);
        chk(irq == 1'b1, "R9 irq from rd_pend", irq, 1);
        tick();
        chk(rd_data[7] == 1'b1, "R10 flag set", rd_data[7], 1);

        msg_start = 1'b1; tick();
        chk(rd_data[5] == 1'b1, "R5 deaf set", rd_data[5], 1);

        addr_match = 1'b1; last_rd = 1'b1; tick();
        chk(rd_data[4] == 1'b1, "R4 set wins", rd_data[4], 1);
        last_rd = 1'b1; tick();
        chk(rd_data[4] == 1'b0, "R4 last read clears", rd_data[4], 0);

        wr_en = 1'b1; wr_data = 8'h00; tick();
        chk(rd_data[7] == 1'b1, "R10 write zero keeps flag", rd_data[7], 1);
        wr_en = 1'b1; wr_data = 8'h80; tick();
        chk(rd_data[7] == 1'b0, "R10 write one clears", rd_data[7], 0);
        chk(rd_data[5] == 1'b1, "R11 deaf kept on write", rd_data[5], 1);

        msg_start = 1'b1; tick();
        chk(rd_data[5] == 1'b0, "R6 deaf cleared", rd_data[5], 0);

        bus_state = 6'd36; sdata = 1'b1; tick();
        chk(rd_data[3] == 1'b0, "R7 no set when not master", rd_data[3], 0);
        master_in = 1'b1; tick();
        chk(rd_data[1] == 1'b1, "R8 master follows", rd_data[1], 1);
        tick();
        chk(rd_data[3] == 1'b1, "R7 nack set", rd_data[3], 1);
        bus_state = 6'd35; msg_start = 1'b1; tick();
        chk(rd_data[3] == 1'b0, "R7 start clears nack", rd_data[3], 0);

        for (int i = 0; i < 4000; i++) begin
            wr_en      = ($urandom_range(0, 7) == 0);
            wr_data    = 8'($urandom);
            bus_irq_en = ($urandom_range(0, 3) != 0);
            bus_state  = 6'($urandom_range(33, 39));
            sdata      = 1'($urandom);
            master_in  = ($urandom_range(0, 3) == 0) ? ~master_in : master_in;
            wr_pend_in = 1'($urandom);
            addr_match = ($urandom_range(0, 9) == 0);
            msg_start  = ($urandom_range(0, 9) == 0);
            last_rd    = ($urandom_range(0, 7) == 0);
            @(negedge clk);
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule